// File: doc/BRIEF.md
# SIMD Floating-Point Minimum/Maximum Unit

This execution unit takes two 128-bit source registers and returns, lane by lane, the lesser or the greater of the two floating-point values. The opcode selects min or max, single or double precision, and packed or scalar form. Packed single precision works on four 32-bit lanes and packed double precision on two 64-bit lanes. Scalar forms work only on the lowest lane and copy the rest of the first source into the result.

The selection does not commute. When the two values compare equal, the second operand wins, and that includes zeros of opposite sign. When either value is a NaN, the second operand's bits are returned unchanged and no quiet NaN is made. Each operation reports an invalid flag for a NaN and a denormal flag for a subnormal input. Three control inputs come from the surrounding status register: a mask for each exception and a denormals-are-zero switch. If a raised exception is not masked, the unit signals a fault and does not deliver the result.

The unit has one register stage. The result, the flags and the fault appear on the clock edge after the valid input.

Top module: `fpmm_unit`

## Requirements
- R1: Packed single precision (op = 3'b000 min, 3'b001 max) treats bits [32k+31:32k], for k = 0..3, as four independent lanes. Each lane's result goes to the same bit positions.
- R2: Packed double precision (op = 3'b100 min, 3'b101 max) treats bits [63:0] and [127:64] as two independent lanes.
- R3: Scalar single precision (op = 3'b010 / 3'b011) computes bits [31:0] only. Result bits [127:32] equal src_a bits [127:32].
- R4: Scalar double precision (op = 3'b110 / 3'b111) computes bits [63:0] only. Result bits [127:64] equal src_a bits [127:64].
- R5: Op bit 0 set selects max and clear selects min. Ordering is by sign and magnitude: any negative value is below any positive value, and among negatives a larger magnitude is lower. When the values are equal, the lane returns src_b.
- R6: When both lane values are zero, whatever their signs, the lane returns src_b.
- R7: A signalling or quiet NaN in either operand of an active lane makes the lane return src_b's raw bits and sets flag bit 0 (invalid).
- R8: A subnormal operand in an active lane sets flag bit 1 (denormal) when dz_en is low. When dz_en is high, the subnormal compares and is returned as a zero of its own sign, and flag bit 1 stays clear.
- R9: If the invalid flag is raised while mask_inv is low, or the denormal flag is raised while mask_den is low, then out_fault pulses and out_vld stays low. out_res keeps its previous value and out_flags still reports the raised bits.
- R10: Outputs appear one clock after in_vld. Without in_vld, out_vld, out_fault and out_flags are zero the next cycle. A synchronous reset clears every output.
- R11: In the scalar forms, only lane 0 can raise flags or a fault. NaN or subnormal data in the copied upper bits is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operation strobe |
| src_a | input | 128 | First source, also supplies copied upper bits in scalar forms |
| src_b | input | 128 | Second source |
| op | input | 3 | bit2 double, bit1 scalar, bit0 max |
| dz_en | input | 1 | Treat subnormal inputs as signed zero |
| mask_inv | input | 1 | Invalid-operation exception masked |
| mask_den | input | 1 | Denormal-operand exception masked |
| out_vld | output | 1 | Result written this cycle |
| out_res | output | 128 | Registered result |
| out_flags | output | 2 | Sticky flag update: bit0 invalid, bit1 denormal |
| out_fault | output | 1 | Unmasked exception, result suppressed |

## Verification
Every result, flag and fault is due exactly one rising edge after the cycle in which in_vld is high. The bench drives inputs on the falling edge and holds in_vld for one rising edge. It then compares all four outputs on the next falling edge, so each check reads the register loaded by that edge and nothing else. Idle and reset checks sample one cycle after the stimulus is withdrawn. This confirms that the strobes and flags have cleared while out_res keeps its last written value.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

    localparam int SP_W   = 32;
    localparam int SP_EXP = 8;
    localparam int DP_W   = 64;
    localparam int DP_EXP = 11;

    // op encoding: {dbl, scalar, is_max}
    typedef struct packed {
        logic dbl;
        logic scalar;
        logic is_max;
    } fp_op_t;

    // flag vector: bit1 denormal, bit0 invalid
    typedef struct packed {
        logic den;
        logic inv;
    } fp_flags_t;

    function automatic logic lane_active(input fp_op_t o, input int idx);
        return !o.scalar || (idx == 0);
    endfunction

endpackage

// File: rtl/fpmm_lane.sv
module fpmm_lane #(
    parameter int W     = 32,
    parameter int EXP_W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_max,
    input  logic         daz,
    output logic [W-1:0] res,
    output logic         inv,
    output logic         den
);
    localparam int MAN_W = W - 1 - EXP_W;

    logic [EXP_W-1:0] ea, eb;
    logic [MAN_W-1:0] ma, mb;
    logic             a_nan, b_nan, a_sub, b_sub;
    logic [W-1:0]     a_eff, b_eff;
    logic [W-2:0]     mag_a, mag_b;
    logic             sgn_a, sgn_b;
    logic             a_gt, a_lt, pick_a;

    assign ea = a[W-2 -: EXP_W];
    assign eb = b[W-2 -: EXP_W];
    assign ma = a[MAN_W-1:0];
    assign mb = b[MAN_W-1:0];

    assign a_nan = (&ea) && (|ma);
    assign b_nan = (&eb) && (|mb);
    assign a_sub = (~|ea) && (|ma);
    assign b_sub = (~|eb) && (|mb);

    // flush subnormals to a signed zero when requested
    assign a_eff = (daz && a_sub) ? {a[W-1], {(W-1){1'b0}}} : a;
    assign b_eff = (daz && b_sub) ? {b[W-1], {(W-1){1'b0}}} : b;

    assign sgn_a = a_eff[W-1];
    assign sgn_b = b_eff[W-1];
    assign mag_a = a_eff[W-2:0];
    assign mag_b = b_eff[W-2:0];

    // strict sign-magnitude ordering; equal values give neither
    always_comb begin
        a_gt = 1'b0;
        a_lt = 1'b0;
        if (sgn_a != sgn_b) begin
            if ((|mag_a) || (|mag_b)) begin
                a_gt = sgn_b;
                a_lt = sgn_a;
            end
        end else if (sgn_a) begin
            a_gt = mag_a < mag_b;
            a_lt = mag_a > mag_b;
        end else begin
            a_gt = mag_a > mag_b;
            a_lt = mag_a < mag_b;
        end
    end

    assign pick_a = is_max ? a_gt : a_lt;
    assign inv    = a_nan || b_nan;
    assign den    = (a_sub || b_sub) && !daz;

    always_comb begin
        if (inv)         res = b;
        else if (pick_a) res = a_eff;
        else             res = b_eff;
    end

endmodule

// File: rtl/fpmm_datapath.sv
module fpmm_datapath
    import fpmm_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  fp_op_t            op,
    input  logic              daz,
    output logic [DATA_W-1:0] res,
    output fp_flags_t         flags
);
    localparam int SP_N = DATA_W / SP_W;
    localparam int DP_N = DATA_W / DP_W;

    logic [SP_N-1:0][SP_W-1:0] sp_res;
    logic [SP_N-1:0]           sp_inv, sp_den;
    logic [DP_N-1:0][DP_W-1:0] dp_res;
    logic [DP_N-1:0]           dp_inv, dp_den;

    for (genvar i = 0; i < SP_N; i++) begin : g_sp
        fpmm_lane #(.W(SP_W), .EXP_W(SP_EXP)) u_lane (
            .a      (a[i*SP_W +: SP_W]),
            .b      (b[i*SP_W +: SP_W]),
            .is_max (op.is_max),
            .daz    (daz),
            .res    (sp_res[i]),
            .inv    (sp_inv[i]),
            .den    (sp_den[i])
        );
    end

    for (genvar i = 0; i < DP_N; i++) begin : g_dp
        fpmm_lane #(.W(DP_W), .EXP_W(DP_EXP)) u_lane (
            .a      (a[i*DP_W +: DP_W]),
            .b      (b[i*DP_W +: DP_W]),
            .is_max (op.is_max),
            .daz    (daz),
            .res    (dp_res[i]),
            .inv    (dp_inv[i]),
            .den    (dp_den[i])
        );
    end

    // inactive lanes pass src a through and contribute no flags
    always_comb begin
        res   = a;
        flags = '0;
        if (op.dbl) begin
            for (int i = 0; i < DP_N; i++) begin
                if (lane_active(op, i)) begin
                    res[i*DP_W +: DP_W] = dp_res[i];
                    flags.inv = flags.inv | dp_inv[i];
                    flags.den = flags.den | dp_den[i];
                end
            end
        end else begin
            for (int i = 0; i < SP_N; i++) begin
                if (lane_active(op, i)) begin
                    res[i*SP_W +: SP_W] = sp_res[i];
                    flags.inv = flags.inv | sp_inv[i];
                    flags.den = flags.den | sp_den[i];
                end
            end
        end
    end

endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
    import fpmm_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [2:0]        op,
    input  logic              dz_en,
    input  logic              mask_inv,
    input  logic              mask_den,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_res,
    output logic [1:0]        out_flags,
    output logic              out_fault
);
    fp_op_t            op_s;
    logic [DATA_W-1:0] dp_res;
    fp_flags_t         dp_flags;
    logic              fault_c;

    assign op_s = fp_op_t'(op);

    fpmm_datapath #(.DATA_W(DATA_W)) u_dp (
        .a     (src_a),
        .b     (src_b),
        .op    (op_s),
        .daz   (dz_en),
        .res   (dp_res),
        .flags (dp_flags)
    );

    assign fault_c = (dp_flags.inv && !mask_inv) || (dp_flags.den && !mask_den);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld   <= 1'b0;
            out_fault <= 1'b0;
            out_flags <= '0;
            out_res   <= '0;
        end else begin
            out_vld   <= in_vld && !fault_c;
            out_fault <= in_vld && fault_c;
            out_flags <= in_vld ? dp_flags : 2'b00;
            if (in_vld && !fault_c)
                out_res <= dp_res;
        end
    end

    // R9: a faulting operation never also reports a written result
    a_r9_fault_excl: assert property (@(posedge clk) disable iff (rst)
        !(out_vld && out_fault));

    // R9: result register untouched on a fault cycle
    a_r9_fault_hold: assert property (@(posedge clk) disable iff (rst)
        out_fault |-> $stable(out_res));

    // R10: every accepted strobe answers on the next edge
    a_r10_latency: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> (out_vld || out_fault));

    // R10: no strobe, no output activity
    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!out_vld && !out_fault && out_flags == 2'b00));

    // R3: scalar single keeps upper bits of src_a
    a_r3_upper_keep: assert property (@(posedge clk) disable iff (rst)
        (in_vld && op[2:1] == 2'b01 && !fault_c)
        |=> out_res[DATA_W-1:32] == $past(src_a[DATA_W-1:32]));

    // R4: scalar double keeps upper bits of src_a
    a_r4_upper_keep: assert property (@(posedge clk) disable iff (rst)
        (in_vld && op[2:1] == 2'b11 && !fault_c)
        |=> out_res[DATA_W-1:64] == $past(src_a[DATA_W-1:64]));

endmodule

// File: tb/fpmm_unit_tb.sv
module fpmm_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_vld = 1'b0;
    logic [127:0] src_a = '0, src_b = '0;
    logic [2:0]   op = '0;
    logic         dz_en = 1'b0, mask_inv = 1'b1, mask_den = 1'b1;
    logic         out_vld, out_fault;
    logic [127:0] out_res;
    logic [1:0]   out_flags;

    int n_checks = 0;
    int n_errors = 0;
    logic [127:0] last_res = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpmm_unit dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld), .src_a(src_a), .src_b(src_b),
        .op(op), .dz_en(dz_en), .mask_inv(mask_inv), .mask_den(mask_den),
        .out_vld(out_vld), .out_res(out_res), .out_flags(out_flags),
        .out_fault(out_fault)
    );

    function automatic logic [31:0] sp_val(input int i);
        case (i)
            0: return 32'h0000_0000;  1: return 32'h8000_0000;
            2: return 32'h0000_0001;  3: return 32'h8040_0000;
            4: return 32'h3f80_0000;  5: return 32'hbf80_0000;
            6: return 32'h4000_0000;  7: return 32'hc000_0000;
            8: return 32'h7f80_0000;  9: return 32'hff80_0000;
            10: return 32'h7fc0_0000; default: return 32'h7f80_0001;
        endcase
    endfunction

    function automatic logic [63:0] dp_val(input int i);
        case (i)
            0: return 64'h0;                    1: return 64'h8000_0000_0000_0000;
            2: return 64'h0000_0000_0000_0001;  3: return 64'h8008_0000_0000_0000;
            4: return 64'h3ff0_0000_0000_0000;  5: return 64'hbff0_0000_0000_0000;
            6: return 64'h4000_0000_0000_0000;  7: return 64'hc000_0000_0000_0000;
            8: return 64'h7ff0_0000_0000_0000;  9: return 64'hfff0_0000_0000_0000;
            10: return 64'h7ff8_0000_0000_0000; default: return 64'h7ff0_0000_0000_0001;
        endcase
    endfunction

    // arithmetic reference: values mapped to signed integer keys
    function automatic void lane_model(input logic [63:0] a, input logic [63:0] b,
                                       input bit dp, input bit mx, input bit daz,
                                       output logic [63:0] r, output bit nan_o, output bit den_o);
        logic [10:0] ea, eb, emax;
        logic [51:0] ma, mb;
        logic [63:0] ae, be;
        logic signed [64:0] ka, kb;
        bit an, bn, ad, bd;
        emax = dp ? 11'h7ff : 11'h0ff;
        if (dp) begin
            ea = a[62:52]; ma = a[51:0]; eb = b[62:52]; mb = b[51:0];
        end else begin
            ea = {3'b0, a[30:23]}; ma = {29'b0, a[22:0]};
            eb = {3'b0, b[30:23]}; mb = {29'b0, b[22:0]};
        end
        an = (ea == emax) && (ma != 0); bn = (eb == emax) && (mb != 0);
        ad = (ea == 0) && (ma != 0);    bd = (eb == 0) && (mb != 0);
        nan_o = an || bn;
        den_o = (ad || bd) && !daz;
        ae = a; be = b;
        if (daz && ad) ae = dp ? {a[63], 63'b0} : {32'b0, a[31], 31'b0};
        if (daz && bd) be = dp ? {b[63], 63'b0} : {32'b0, b[31], 31'b0};
        ka = dp ? $signed({2'b0, ae[62:0]}) : $signed({34'b0, ae[30:0]});
        kb = dp ? $signed({2'b0, be[62:0]}) : $signed({34'b0, be[30:0]});
        if (dp ? ae[63] : ae[31]) ka = -ka;
        if (dp ? be[63] : be[31]) kb = -kb;
        if (nan_o)   r = b;
        else if (mx) r = (ka > kb) ? ae : be;
        else         r = (ka < kb) ? ae : be;
    endfunction

    task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic [2:0] o,
                          input bit daz, input bit im, input bit dm, input string tag);
        logic [127:0] e_res;
        logic [63:0]  r;
        bit nan_l, den_l, e_inv, e_den, e_fault;
        e_res = a; e_inv = 0; e_den = 0;
        if (o[2]) begin
            for (int k = 0; k < 2; k++) begin
                if (!o[1] || k == 0) begin
                    lane_model(a[64*k +: 64], b[64*k +: 64], 1'b1, o[0], daz, r, nan_l, den_l);
                    e_res[64*k +: 64] = r;
                    e_inv |= nan_l; e_den |= den_l;
                end
            end
        end else begin
            for (int k = 0; k < 4; k++) begin
                if (!o[1] || k == 0) begin
                    lane_model({32'b0, a[32*k +: 32]}, {32'b0, b[32*k +: 32]}, 1'b0, o[0], daz, r, nan_l, den_l);
                    e_res[32*k +: 32] = r[31:0];
                    e_inv |= nan_l; e_den |= den_l;
                end
            end
        end
        e_fault = (e_inv && !im) || (e_den && !dm);
        if (e_fault) e_res = last_res;
        @(negedge clk);
        src_a = a; src_b = b; op = o; dz_en = daz; mask_inv = im; mask_den = dm; in_vld = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_vld = 1'b0;
        n_checks++;
        if (out_res !== e_res || out_flags !== {e_den, e_inv} ||
            out_vld !== !e_fault || out_fault !== e_fault) begin
            n_errors++;
            $display("FAIL %s: res=%h flags=%b vld=%b fault=%b expected res=%h flags=%b vld=%b fault=%b",
                     tag, out_res, out_flags, out_vld, out_fault,
                     e_res, {e_den, e_inv}, !e_fault, e_fault);
        end
        last_res = e_res;
    endtask

    task automatic check_quiet(input logic [127:0] e_res, input string tag);
        n_checks++;
        if (out_vld !== 1'b0 || out_fault !== 1'b0 || out_flags !== 2'b00 || out_res !== e_res) begin
            n_errors++;
            $display("FAIL %s: res=%h flags=%b vld=%b fault=%b expected res=%h flags=00 vld=0 fault=0",
                     tag, out_res, out_flags, out_vld, out_fault, e_res);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : stim
        logic [127:0] a, b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_quiet(128'h0, "R10 reset state");

        // sweeps: R1 packed single, R3 scalar single, R2 packed double, R4 scalar double
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int k = 0; k < 4; k++) begin
                        a[32*k +: 32] = sp_val((i + k) % 12);
                        b[32*k +: 32] = sp_val((j + 3*k) % 12);
                    end
                    run_op(a, b, {2'b00, m[0]}, m[1], 1'b1, 1'b1, "R1");
                    run_op(a, b, {2'b01, m[0]}, m[1], 1'b1, 1'b1, "R3");
                    for (int k = 0; k < 2; k++) begin
                        a[64*k +: 64] = dp_val((i + k) % 12);
                        b[64*k +: 64] = dp_val((j + 5*k) % 12);
                    end
                    run_op(a, b, {2'b10, m[0]}, m[1], 1'b1, 1'b1, "R2");
                    run_op(a, b, {2'b11, m[0]}, m[1], 1'b1, 1'b1, "R4");
                end
            end
        end

        // R5 ordering: max(1,2)=2, min(-2,-1)=-2
        run_op({96'h0, 32'h3f80_0000}, {96'h0, 32'h4000_0000}, 3'b011, 0, 1, 1, "R5");
        run_op({96'h0, 32'hc000_0000}, {96'h0, 32'hbf80_0000}, 3'b010, 0, 1, 1, "R5");
        // R6 signed zeros return src_b
        run_op({96'h0, 32'h0000_0000}, {96'h0, 32'h8000_0000}, 3'b011, 0, 1, 1, "R6");
        run_op({96'h0, 32'h8000_0000}, {96'h0, 32'h0000_0000}, 3'b010, 0, 1, 1, "R6");
        // R7 quiet NaN in a returns b, invalid flag
        run_op({96'h0, 32'h7fc0_0000}, {96'h0, 32'h3f80_0000}, 3'b011, 0, 1, 1, "R7");
        // R8 subnormal with and without flush
        run_op({96'h0, 32'h0000_0001}, {96'h0, 32'h8000_0000}, 3'b011, 0, 1, 1, "R8");
        run_op({96'h0, 32'h0000_0001}, {96'h0, 32'h8000_0000}, 3'b011, 1, 1, 1, "R8");
        // R11 NaN and subnormal in ignored upper bits of scalar forms
        run_op({32'h7f80_0001, 32'h0000_0001, 32'h7fc0_0000, 32'h4000_0000},
               {32'h7f80_0001, 32'h0000_0001, 32'h7fc0_0000, 32'h3f80_0000}, 3'b011, 0, 0, 0, "R11");
        run_op({64'h7ff0_0000_0000_0001, 64'h3ff0_0000_0000_0000},
               {64'h0000_0000_0000_0001, 64'h4000_0000_0000_0000}, 3'b110, 0, 0, 0, "R11");
        // R9 unmasked invalid and unmasked denormal fault, result held
        run_op({96'h0, 32'h7f80_0001}, {96'h0, 32'h3f80_0000}, 3'b011, 0, 0, 1, "R9");
        run_op({96'h0, 32'h0000_0001}, {96'h0, 32'h3f80_0000}, 3'b010, 0, 1, 0, "R9");
        run_op({96'h0, 32'h0000_0001}, {96'h0, 32'h3f80_0000}, 3'b010, 1, 1, 0, "R9 flushed");
        run_op({64'h0, 64'h7ff8_0000_0000_0000}, {64'h0, 64'h0}, 3'b101, 0, 0, 1, "R9");

        // R10 idle cycle: strobes and flags drop, result kept
        @(negedge clk);
        check_quiet(last_res, "R10 idle");
        // R10 synchronous reset clears outputs
        run_op({96'h0, 32'h4000_0000}, {96'h0, 32'h3f80_0000}, 3'b011, 0, 1, 1, "R10");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_quiet(128'h0, "R10 reset clear");
        last_res = '0;

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule